// File: doc/BRIEF.md
# Scrambled-Address Memory Map Decoder with Wait-State Timing

This block sits between a small 20-bit stack processor and its external memory and I/O. Software presents a numeric word address. The block flips alternate bits of that address to get the pattern that physically appears on the bus, and finds which of seven targets the pattern belongs to. The targets are a large DRAM, slow and fast byte-wide memories, slow and fast 1K-word 20-bit SRAMs, a memory-mapped I/O window and an internal 20-bit configuration register. The chosen target's select line is held for the whole access. The block counts that target's access time in clock cycles, and a one-cycle ready pulse ends the access.

DRAM is divided into 1K-word pages. The block remembers the last page used, and a DRAM access to any other page takes extra cycles. The two low bits of the configuration register form a bank number, which is driven out to choose one of four external pages in the byte-wide regions. One bank value diverts the slow byte-wide page to the I/O select in place of the memory select. An address that matches no target completes in one cycle with an error flag and no select.

Top module: `mmap_wait_ctrl`

## Requirements
- R1: The physical pattern is the 21-bit request address XOR 0x0AAAAA. Pattern bit 20 clear selects DRAM. Bits 20:18 = 100 select the slow byte region and 101 the fast byte region. Bits 20:10 equal to 0x180000>>10 select the slow 20-bit SRAM, and equal to 0x1C0000>>10 the fast 20-bit SRAM. The exact pattern 0x1E0000 selects the configuration register. At most one select is high at any time.
- R2: Counting from the clock edge that accepts a request, the select is high for L cycles and ready is high in the last of them. L is 4 (LAT_FAST) for the fast byte and fast 20-bit regions, and 25 (LAT_SLOW) for the slow byte, slow 20-bit and I/O targets.
- R3: The DRAM page is pattern bits 19:10. A DRAM access to the stored page takes LAT_DRAM = 6 cycles. An access to any other page takes LAT_DRAM + LAT_MISS = 16 cycles. The stored page becomes the page of every DRAM access.
- R4: An address that matches no target raises no select. Ready and decode_err are both high in the cycle after acceptance.
- R5: An access to the configuration register takes 1 cycle. A write stores req_wdata. A read shows the stored 20-bit value on rd_data in its ready cycle. At all other times rd_data is 0.
- R6: bank_out always equals configuration bits 1:0. In the slow byte region, bank value 2'b10 raises cs_io in place of cs_slow8. The other three values raise cs_slow8. The fast byte region does not depend on the bank.
- R7: A request is accepted only while no access is in progress. Address changes during an access have no effect. The select stays constant through the access and drops in the cycle after the single ready pulse.
- R8: After reset, no select, ready, decode_err or rd_data is high, bank_out is 0, and the page memory is empty, so the first DRAM access takes the miss time.
- R9: The 20-bit SRAM regions cover 1K words only. The pattern one word above either region, and any pattern near the configuration register other than 0x1E0000, is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; hold until ready |
| req_addr | input | 21 | Software (numeric) word address |
| req_we | input | 1 | Write when high, read when low |
| req_wdata | input | 20 | Write data (used by the configuration register) |
| req_ready | output | 1 | One-cycle pulse that ends the access |
| rd_data | output | 20 | Configuration read data in the ready cycle, else 0 |
| decode_err | output | 1 | High with ready when the address matched no target |
| cs_dram | output | 1 | DRAM select |
| cs_slow8 | output | 1 | Slow byte-wide memory select |
| cs_fast8 | output | 1 | Fast byte-wide memory select |
| cs_slow20 | output | 1 | Slow 20-bit SRAM select |
| cs_fast20 | output | 1 | Fast 20-bit SRAM select |
| cs_io | output | 1 | Memory-mapped I/O select |
| cs_cfg | output | 1 | Configuration register access indicator |
| bank_out | output | 2 | External page number for the byte-wide regions |

## Verification
A wrong page memory shows only through timing. A stale or missing stored page turns the next DRAM access to the same page into a 16-cycle access, or the next access to another page into a 6-cycle one. The ready pulse therefore lands ten cycles early or late on the very next DRAM access. A wrong configuration bank first shows on bank_out. It then shows at the next slow byte-wide access, when the wrong one of cs_io and cs_slow8 rises one cycle after acceptance. A wrong latched select or counter shows in the same access as a missing, doubled or moved select or ready edge.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  localparam int unsigned ADDR_W   = 21;
  localparam int unsigned DATA_W   = 20;
  localparam int unsigned BANK_W   = 2;
  localparam int unsigned SMALL_AW = 10;               // 1K-word spaces and DRAM pages
  localparam int unsigned PAGE_W   = DATA_W - SMALL_AW;
  localparam int unsigned NUM_CS   = 7;

  localparam logic [ADDR_W-1:0] SLOW20_BASE = 21'h180000;
  localparam logic [ADDR_W-1:0] FAST20_BASE = 21'h1C0000;
  localparam logic [ADDR_W-1:0] CFG_ADDR    = 21'h1E0000;
  localparam logic [2:0]        SLOW8_TAG   = 3'b100;
  localparam logic [2:0]        FAST8_TAG   = 3'b101;

  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_DRAM   = 3'd1,
    RG_SLOW8  = 3'd2,
    RG_FAST8  = 3'd3,
    RG_SLOW20 = 3'd4,
    RG_FAST20 = 3'd5,
    RG_IO     = 3'd6,
    RG_CFG    = 3'd7
  } region_e;

  // select vector bit i belongs to region code i+1
  localparam int unsigned CSB_CFG = 6;

  function automatic logic [NUM_CS-1:0] region_onehot(region_e r);
    logic [NUM_CS-1:0] v;
    v = '0;
    if (r != RG_NONE) v[int'(r) - 1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/mmap_region_dec.sv
module mmap_region_dec
  import mmap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] XOR_MASK = 21'h0AAAAA,
  parameter logic [BANK_W-1:0] IO_BANK  = 2'b10
) (
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [BANK_W-1:0] bank,
  output region_e           region,
  output logic [PAGE_W-1:0] page
);

  localparam int unsigned TAG_W = ADDR_W - SMALL_AW;

  logic [ADDR_W-1:0] phys;
  logic [TAG_W-1:0]  tag;

  assign phys = sw_addr ^ XOR_MASK;
  assign tag  = phys[ADDR_W-1:SMALL_AW];
  assign page = phys[DATA_W-1:SMALL_AW];

  always_comb begin
    region = RG_NONE;
    if (!phys[ADDR_W-1]) begin
      region = RG_DRAM;
    end else if (phys[ADDR_W-1 -: 3] == SLOW8_TAG) begin
      region = (bank == IO_BANK) ? RG_IO : RG_SLOW8;
    end else if (phys[ADDR_W-1 -: 3] == FAST8_TAG) begin
      region = RG_FAST8;
    end else if (tag == SLOW20_BASE[ADDR_W-1:SMALL_AW]) begin
      region = RG_SLOW20;
    end else if (tag == FAST20_BASE[ADDR_W-1:SMALL_AW]) begin
      region = RG_FAST20;
    end else if (phys == CFG_ADDR) begin
      region = RG_CFG;
    end
  end

endmodule

// File: rtl/mmap_page_track.sv
module mmap_page_track
  import mmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [PAGE_W-1:0] page_in,
  output logic              miss
);

  logic [PAGE_W-1:0] page_q, page_d;
  logic              vld_q, vld_d;

  assign miss = !vld_q || (page_q != page_in);

  always_comb begin
    page_d = page_q;
    vld_d  = vld_q;
    if (upd) begin
      page_d = page_in;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      page_q <= page_d;
      vld_q  <= vld_d;
    end
  end

endmodule

// File: rtl/mmap_wait_timer.sv
module mmap_wait_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign busy = busy_q;
  assign last = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = load - CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/mmap_cfg_reg.sv
module mmap_cfg_reg
  import mmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic [BANK_W-1:0] bank
);

  logic [DATA_W-1:0] cfg_q, cfg_d;

  assign value = cfg_q;
  assign bank  = cfg_q[BANK_W-1:0];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

endmodule

// File: rtl/mmap_wait_ctrl.sv
module mmap_wait_ctrl
  import mmap_pkg::*;
#(
  parameter int unsigned       LAT_FAST = 4,
  parameter int unsigned       LAT_SLOW = 25,
  parameter int unsigned       LAT_DRAM = 6,
  parameter int unsigned       LAT_MISS = 10,
  parameter logic [ADDR_W-1:0] XOR_MASK = 21'h0AAAAA,
  parameter logic [BANK_W-1:0] IO_BANK  = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [20:0]       req_addr,
  input  logic              req_we,
  input  logic [19:0]       req_wdata,
  output logic              req_ready,
  output logic [19:0]       rd_data,
  output logic              decode_err,
  output logic              cs_dram,
  output logic              cs_slow8,
  output logic              cs_fast8,
  output logic              cs_slow20,
  output logic              cs_fast20,
  output logic              cs_io,
  output logic              cs_cfg,
  output logic [1:0]        bank_out
);

  localparam int unsigned MAX_LAT = ((LAT_DRAM + LAT_MISS) > LAT_SLOW) ?
                                    (LAT_DRAM + LAT_MISS) : LAT_SLOW;
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);

  region_e           region_d;
  logic [PAGE_W-1:0] page_d;
  logic              page_miss;
  logic              busy, last, accept;
  logic [CNT_W-1:0]  lat_d;
  logic [DATA_W-1:0] cfg_value;
  logic [BANK_W-1:0] bank;
  logic              cfg_wr;

  logic [NUM_CS-1:0] cs_q, cs_d;
  logic              err_q, err_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  assign accept = req_valid && !busy;

  mmap_region_dec #(
    .XOR_MASK (XOR_MASK),
    .IO_BANK  (IO_BANK)
  ) u_dec (
    .sw_addr (req_addr),
    .bank    (bank),
    .region  (region_d),
    .page    (page_d)
  );

  mmap_page_track u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (accept && (region_d == RG_DRAM)),
    .page_in (page_d),
    .miss    (page_miss)
  );

  // access time for the target being accepted
  always_comb begin
    unique case (region_d)
      RG_DRAM:                       lat_d = page_miss ? CNT_W'(LAT_DRAM + LAT_MISS)
                                                       : CNT_W'(LAT_DRAM);
      RG_SLOW8, RG_IO, RG_SLOW20:    lat_d = CNT_W'(LAT_SLOW);
      RG_FAST8, RG_FAST20:           lat_d = CNT_W'(LAT_FAST);
      default:                       lat_d = CNT_W'(1);
    endcase
  end

  mmap_wait_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .load  (lat_d),
    .busy  (busy),
    .last  (last)
  );

  assign cfg_wr = last && cs_q[CSB_CFG] && we_q;

  mmap_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .wdata (wdata_q),
    .value (cfg_value),
    .bank  (bank)
  );

  // request capture: selects, error and write attributes held per access
  always_comb begin
    cs_d    = cs_q;
    err_d   = err_q;
    we_d    = we_q;
    wdata_d = wdata_q;
    if (accept) begin
      cs_d    = region_onehot(region_d);
      err_d   = (region_d == RG_NONE);
      we_d    = req_we;
      wdata_d = req_wdata;
    end else if (last) begin
      cs_d  = '0;
      err_d = 1'b0;
      we_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '0;
      err_q   <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      cs_q    <= cs_d;
      err_q   <= err_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
    end
  end

  assign req_ready  = last;
  assign decode_err = last && err_q;
  assign rd_data    = (last && cs_q[CSB_CFG] && !we_q) ? cfg_value : '0;
  assign bank_out   = bank;

  assign cs_dram   = cs_q[0];
  assign cs_slow8  = cs_q[1];
  assign cs_fast8  = cs_q[2];
  assign cs_slow20 = cs_q[3];
  assign cs_fast20 = cs_q[4];
  assign cs_io     = cs_q[5];
  assign cs_cfg    = cs_q[6];

endmodule

// File: rtl/mmap_wait_ctrl_chk.sv
module mmap_wait_ctrl_chk #(
  parameter logic [1:0] IO_BANK = 2'b10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic [19:0] rd_data,
  input logic        decode_err,
  input logic        cs_dram,
  input logic        cs_slow8,
  input logic        cs_fast8,
  input logic        cs_slow20,
  input logic        cs_fast20,
  input logic        cs_io,
  input logic        cs_cfg,
  input logic [1:0]  bank_out
);

  logic [6:0] csv;
  assign csv = {cs_cfg, cs_io, cs_fast20, cs_slow20, cs_fast8, cs_slow8, cs_dram};

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(csv)); // R1

  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err |-> (csv == 7'd0 && req_ready)); // R4

  AST_RD_ONLY_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != 20'd0) |-> (req_ready && cs_cfg)); // R5

  AST_IO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    cs_io |-> (bank_out == IO_BANK)); // R6

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((csv != 7'd0) && !req_ready) |=> $stable(csv)); // R7

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (!req_ready && csv == 7'd0)); // R7

endmodule

bind mmap_wait_ctrl mmap_wait_ctrl_chk #(.IO_BANK(IO_BANK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rd_data    (rd_data),
  .decode_err (decode_err),
  .cs_dram    (cs_dram),
  .cs_slow8   (cs_slow8),
  .cs_fast8   (cs_fast8),
  .cs_slow20  (cs_slow20),
  .cs_fast20  (cs_fast20),
  .cs_io      (cs_io),
  .cs_cfg     (cs_cfg),
  .bank_out   (bank_out)
);

// File: tb/mmap_wait_ctrl_tb.sv
module mmap_wait_ctrl_tb;

  localparam logic [20:0] MASK = 21'h0AAAAA;

  logic        clk, rst_n;
  logic        req_valid, req_we;
  logic [20:0] req_addr;
  logic [19:0] req_wdata;
  logic        req_ready, decode_err;
  logic [19:0] rd_data;
  logic        cs_dram, cs_slow8, cs_fast8, cs_slow20, cs_fast20, cs_io, cs_cfg;
  logic [1:0]  bank_out;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference state
  logic [19:0] m_cfg;
  logic [9:0]  m_page;
  bit          m_pvld;

  mmap_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .decode_err(decode_err), .cs_dram(cs_dram),
    .cs_slow8(cs_slow8), .cs_fast8(cs_fast8), .cs_slow20(cs_slow20),
    .cs_fast20(cs_fast20), .cs_io(cs_io), .cs_cfg(cs_cfg), .bank_out(bank_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [6:0] csv();
    return {cs_cfg, cs_io, cs_fast20, cs_slow20, cs_fast8, cs_slow8, cs_dram};
  endfunction

  // region codes: 0 none,1 dram,2 slow8,3 fast8,4 slow20,5 fast20,6 io,7 cfg
  function automatic int model_region(logic [20:0] sw);
    logic [20:0] p;
    p = sw ^ MASK;
    if (!p[20])                          return 1;
    if (p[20:18] == 3'b100)              return (m_cfg[1:0] == 2'b10) ? 6 : 2;
    if (p[20:18] == 3'b101)              return 3;
    if (p[20:10] == 11'h600)             return 4;
    if (p[20:10] == 11'h700)             return 5;
    if (p == 21'h1E0000)                 return 7;
    return 0;
  endfunction

  function automatic int model_lat(int r, logic [20:0] sw);
    logic [20:0] p;
    p = sw ^ MASK;
    case (r)
      1:       return (m_pvld && m_page == p[19:10]) ? 6 : 16;
      2, 4, 6: return 25;
      3, 5:    return 4;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [20:0] phys, input logic we,
                        input logic [19:0] wd, input string req);
    logic [20:0] sw;
    logic [6:0]  first, exp_cs;
    int          r, lat, n;
    bit          stable;
    sw     = phys ^ MASK;
    r      = model_region(sw);
    lat    = model_lat(r, sw);
    exp_cs = (r == 0) ? 7'd0 : 7'(1 << (r - 1));
    @(negedge clk);
    req_valid = 1'b1; req_addr = sw; req_we = we; req_wdata = wd;
    @(negedge clk);
    first  = csv();
    n      = 1;
    stable = 1;
    req_addr  = 21'($urandom);          // R7: must be ignored while busy
    req_wdata = 20'($urandom);
    while (!req_ready && n < 100) begin
      @(negedge clk);
      n++;
      if (csv() != first && !req_ready) stable = 0;
      if (req_ready && csv() != first) stable = 0;
    end
    chk(first == exp_cs, (r == 6 || r == 2) ? "R6" : "R1", "select", first, exp_cs);
    chk(n == lat, (r == 1) ? "R3" : (r == 0 ? "R4" : (r == 7 ? "R5" : "R2")),
        $sformatf("latency phys=%06h", phys), n, lat);
    chk(stable, "R7", "select stable", stable, 1);
    chk(decode_err == (r == 0), "R4", "decode_err", decode_err, (r == 0));
    if (r == 7 && !we) chk(rd_data == m_cfg, "R5", "cfg read", rd_data, m_cfg);
    else               chk(rd_data == 20'd0, "R5", "rd_data idle", rd_data, 0);
    if (r == 1) begin m_page = phys[19:10]; m_pvld = 1; end
    if (r == 7 && we) m_cfg = wd;
    req_valid = 1'b0;
    @(negedge clk);
    chk(csv() == 7'd0 && !req_ready, "R7", "drop after ready", {req_ready, csv()}, 0);
    chk(bank_out == m_cfg[1:0], "R6", "bank_out", bank_out, m_cfg[1:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    m_cfg = '0; m_page = '0; m_pvld = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(csv() == 7'd0 && !req_ready && !decode_err, "R8", "reset outputs",
        {decode_err, req_ready, csv()}, 0);
    chk(rd_data == 0 && bank_out == 0, "R8", "reset cfg", {rd_data, bank_out}, 0);

    // R3/R8 first DRAM access misses, same page hits, new page misses
    access(21'h012345, 0, 0, "R3");
    access(21'h0123FF, 0, 0, "R3");
    access(21'h012400, 1, 0, "R3");
    access(21'h0FFFFF, 0, 0, "R3");
    // R2 region timing
    access(21'h1C0000, 0, 0, "R2");
    access(21'h1C03FF, 1, 0, "R2");
    access(21'h180000, 0, 0, "R2");
    access(21'h13FFFF, 0, 0, "R2");
    access(21'h140000, 0, 0, "R2");
    // R9 edges of the small regions
    access(21'h180400, 0, 0, "R9");
    access(21'h1C0400, 0, 0, "R9");
    access(21'h1E0001, 0, 0, "R9");
    access(21'h1F0000, 0, 0, "R4");
    // R5/R6 config and I/O bank
    access(21'h1E0000, 1, 20'hABC12, "R5");
    access(21'h1E0000, 0, 0, "R5");
    access(21'h100000, 0, 0, "R6");
    access(21'h17FFFF, 0, 0, "R6");
    access(21'h1E0000, 1, 20'h00003, "R6");
    access(21'h120000, 0, 0, "R6");
    access(21'h1E0000, 1, 20'h00001, "R6");
    access(21'h120000, 1, 0, "R6");

    // constrained random mix
    for (int i = 0; i < 250; i++) begin
      int          kind;
      logic [20:0] p;
      kind = $urandom_range(0, 9);
      case (kind)
        0, 1, 2: p = {1'b0, 2'($urandom_range(0, 3)) , 8'h00, 10'($urandom)};
        3:       p = {3'b100, 18'($urandom)};
        4:       p = {3'b101, 18'($urandom)};
        5:       p = {11'h600, 10'($urandom)};
        6:       p = {11'h700, 10'($urandom)};
        7, 8:    p = 21'h1E0000;
        default: p = {1'b1, 20'($urandom)};
      endcase
      access(p, 1'($urandom), 20'($urandom), "R1");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule